// File: doc/BRIEF.md
# Collision-Checking UART Transmitter

This block serialises a nine-bit data word onto a shared, wired-AND style line. It reads the line back while driving it and compares what it drives with what it sees. When the two differ at the moment chosen for the comparison, another driver has taken the line. The block then raises a sticky collision flag and can drop its own transmit enable, so that the frame is abandoned at once.

A frame is a low start bit, nine data bits sent least significant first, and a high stop bit. The frame advances one bit for each pulse on a transfer-clock enable input. The comparison is made either on that pulse or on a one-shot timer underflow pulse supplied from outside. A frame starts in one of two ways. In the first, it starts on the first transfer-clock pulse once transmission is enabled and a word is waiting. In the second, it waits for a falling edge on the readback line, so that it can align to a frame another node has begun. A polarity input inverts both the driven pin and the readback. Receive decoding, baud generation and the timer itself sit outside.

Top module: `uart_bc_tx`

## Requirements
- R1: After reset tx_busy is 0, tx_en is 0, col_flag is 0, load_ready is 1, and txd rests at the mark level: 1 when cfg_invert is 0 and 0 when cfg_invert is 1.
- R2: A frame is made of logical bit 0 (start, level 0), then logical bits 1 to 9 (data bits 0 to 8, least significant first), then logical bit 10 (stop, level 1). Each xfer_tick pulse while tx_busy is 1 moves to the next bit, and the tick that ends the stop bit returns the line to idle.
- R3: When cfg_wait_edge is 0, a frame starts at the first xfer_tick at which tx_en is 1 and a word is pending. The start bit appears on txd in the cycle after that tick, and the line stays idle before it.
- R4: When cfg_wait_edge is 1, a frame starts only on a falling edge of the synchronised logical readback, and only if tx_en is 1 and a word is pending when that edge is seen. An edge seen while these do not hold is ignored, and xfer_tick alone never starts a frame in this mode.
- R5: When cfg_invert is 1, txd is the complement of the logical bit and rxd is complemented before use, so a rising edge on the rxd pin is the start edge.
- R6: When cfg_samp_timer is 0, a difference between the logical bit being driven and the synchronised logical readback at an xfer_tick during a frame sets col_flag in the next cycle.
- R7: When cfg_samp_timer is 1, the comparison is made only at tmr_uf pulses, and a difference present only at xfer_tick pulses does not set col_flag.
- R8: col_flag stays 1 until a col_clr pulse clears it. A new collision in the same cycle as col_clr wins.
- R9: When cfg_auto_off is 1, a collision clears tx_en and returns txd to idle in the same cycle as col_flag rises. When cfg_auto_off is 0, the frame runs to its end and tx_en stays 1.
- R10: A ten_clr pulse in the middle of a frame returns txd to idle and tx_busy to 0 in the next cycle. The next frame starts again from the start bit.
- R11: load_ready is 0 while a word is pending, and a load offered then is ignored. The pending word is taken when a frame starts, which raises load_ready again.
- R12: No comparison is made while no frame is in progress, so readback differences on an idle line leave col_flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_tick | input | 1 | One-cycle transfer-clock enable (bit boundary) |
| tmr_uf | input | 1 | One-cycle timer underflow pulse used as sampling instant |
| cfg_samp_timer | input | 1 | 1: compare at tmr_uf, 0: compare at xfer_tick |
| cfg_auto_off | input | 1 | 1: a collision clears tx_en |
| cfg_wait_edge | input | 1 | 1: start frames on a readback falling edge |
| cfg_invert | input | 1 | 1: invert txd and rxd |
| ten_set | input | 1 | Pulse: set transmit enable |
| ten_clr | input | 1 | Pulse: clear transmit enable (wins over ten_set) |
| load_valid | input | 1 | Data word offered |
| load_data | input | DATA_W | Data word, bit 0 sent first |
| load_ready | output | 1 | Holding register empty |
| rxd | input | 1 | Line readback pin |
| txd | output | 1 | Line drive pin |
| col_flag | output | 1 | Sticky collision request flag |
| col_clr | input | 1 | Pulse: clear col_flag |
| tx_en | output | 1 | Transmit enable state |
| tx_busy | output | 1 | Frame in progress |

## Verification
The assertions assume that the configuration inputs change only while no frame is in progress, that xfer_tick and tmr_uf are single-cycle pulses, and that the line settles to the driven level within the synchroniser delay. The stimulus keeps to these limits. It changes the configuration only between frames and spaces xfer_tick eight cycles apart. It places tmr_uf half a bit after a tick, and it models the line as a wired-AND of txd and a second driver that switches only at bit boundaries. The second driver pulls low for a full bit, so the compare point always sees a settled line.

// File: rtl/uart_bc_pkg.sv
package uart_bc_pkg;
   typedef struct packed {
      logic samp_timer;
      logic auto_off;
      logic wait_edge;
      logic invert;
   } bc_cfg_t;

   localparam logic MARK_LVL  = 1'b1;
   localparam logic SPACE_LVL = 1'b0;
endpackage

// File: rtl/bc_rx_sync.sv
module bc_rx_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_raw,
   input  logic invert,
   output logic line_log,
   output logic fall_log
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= 1'b1;
            else        chain_q <= line_raw;
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], line_raw};
         end
      end
   endgenerate

   assign line_log = chain_q[STAGES-1] ^ invert;
   assign fall_log = prev_q & ~line_log;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= line_log;
   end
endmodule

// File: rtl/bc_load_buf.sv
module bc_load_buf #(
   parameter int unsigned DATA_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              take,
   output logic              in_ready,
   output logic              pending,
   output logic [DATA_W-1:0] word
);
   assign in_ready = ~pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= 1'b0;
         word    <= '0;
      end else if (take) begin
         pending <= 1'b0;
      end else if (in_valid && in_ready) begin
         pending <= 1'b1;
         word    <= in_data;
      end
   end
endmodule

// File: rtl/bc_tx_shifter.sv
module bc_tx_shifter #(
   parameter int unsigned DATA_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              kill,
   input  logic              start,
   input  logic              adv,
   input  logic [DATA_W-1:0] data,
   output logic              busy,
   output logic              bit_log
);
   import uart_bc_pkg::*;
   localparam int unsigned FRAME_W = DATA_W + 2;
   localparam int unsigned CNT_W   = $clog2(FRAME_W);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

   logic [FRAME_W-1:0] sh_q;
   logic [CNT_W-1:0]   left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         sh_q   <= '1;
         left_q <= '0;
      end else if (kill) begin
         busy   <= 1'b0;
         sh_q   <= '1;
         left_q <= '0;
      end else if (start && !busy) begin
         busy   <= 1'b1;
         sh_q   <= {MARK_LVL, data, SPACE_LVL};
         left_q <= LAST_IDX;
      end else if (adv && busy) begin
         if (left_q == '0) begin
            busy <= 1'b0;
            sh_q <= '1;
         end else begin
            sh_q   <= {MARK_LVL, sh_q[FRAME_W-1:1]};
            left_q <= left_q - 1'b1;
         end
      end
   end

   assign bit_log = sh_q[0];
endmodule

// File: rtl/bc_col_det.sv
module bc_col_det (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic tmr_pulse,
   input  logic use_timer,
   input  logic active,
   input  logic tx_bit,
   input  logic rx_bit,
   input  logic clr,
   output logic hit,
   output logic flag
);
   logic sample;

   assign sample = use_timer ? tmr_pulse : tick;
   assign hit    = active & sample & (tx_bit ^ rx_bit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag <= 1'b0;
      else if (hit) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
   end
endmodule

// File: rtl/uart_bc_tx.sv
module uart_bc_tx #(
   parameter int unsigned DATA_W      = 9,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xfer_tick,
   input  logic              tmr_uf,
   input  logic              cfg_samp_timer,
   input  logic              cfg_auto_off,
   input  logic              cfg_wait_edge,
   input  logic              cfg_invert,
   input  logic              ten_set,
   input  logic              ten_clr,
   input  logic              load_valid,
   input  logic [DATA_W-1:0] load_data,
   output logic              load_ready,
   input  logic              rxd,
   output logic              txd,
   output logic              col_flag,
   input  logic              col_clr,
   output logic              tx_en,
   output logic              tx_busy
);
   import uart_bc_pkg::*;

   generate
      if (DATA_W < 5 || DATA_W > 16) begin : g_bad_width
         $error("uart_bc_tx: DATA_W must lie in 5..16");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("uart_bc_tx: SYNC_STAGES must be at least 2");
      end
   endgenerate

   bc_cfg_t           cfg;
   logic              rx_log, rx_fall;
   logic              pending;
   logic [DATA_W-1:0] word;
   logic              col_hit, kill, go_ok, start, bit_log;

   assign cfg = '{samp_timer: cfg_samp_timer, auto_off: cfg_auto_off,
                  wait_edge: cfg_wait_edge, invert: cfg_invert};

   bc_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .line_raw(rxd), .invert(cfg.invert),
      .line_log(rx_log), .fall_log(rx_fall)
   );

   bc_load_buf #(.DATA_W(DATA_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .in_valid(load_valid), .in_data(load_data),
      .take(start), .in_ready(load_ready), .pending(pending), .word(word)
   );

   bc_col_det u_col (
      .clk(clk), .rst_n(rst_n), .tick(xfer_tick), .tmr_pulse(tmr_uf),
      .use_timer(cfg.samp_timer), .active(tx_busy), .tx_bit(bit_log),
      .rx_bit(rx_log), .clr(col_clr), .hit(col_hit), .flag(col_flag)
   );

   assign kill  = ten_clr | (col_hit & cfg.auto_off);
   assign go_ok = tx_en & pending & ~tx_busy & ~kill;
   assign start = go_ok & (cfg.wait_edge ? rx_fall : xfer_tick);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       tx_en <= 1'b0;
      else if (kill)    tx_en <= 1'b0;
      else if (ten_set) tx_en <= 1'b1;
   end

   bc_tx_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .kill(kill | ~tx_en), .start(start),
      .adv(xfer_tick), .data(word), .busy(tx_busy), .bit_log(bit_log)
   );

   assign txd = bit_log ^ cfg.invert;
endmodule

// File: rtl/bc_tx_chk.sv
module bc_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic cfg_invert,
   input logic cfg_auto_off,
   input logic col_clr,
   input logic load_ready,
   input logic txd,
   input logic col_flag,
   input logic tx_en,
   input logic tx_busy
);
   p_idle_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy |-> txd == ~cfg_invert);

   p_start_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_busy) |-> txd == cfg_invert);

   p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      col_flag && !col_clr |=> col_flag);

   p_auto_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(col_flag) && $past(cfg_auto_off) |-> !tx_en);

   p_busy_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tx_busy |-> tx_en);

   p_ready_on_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_busy) |-> load_ready);

   p_no_flag_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy && !col_flag |=> !col_flag);
endmodule

bind uart_bc_tx bc_tx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_invert(cfg_invert), .cfg_auto_off(cfg_auto_off),
   .col_clr(col_clr), .load_ready(load_ready), .txd(txd), .col_flag(col_flag),
   .tx_en(tx_en), .tx_busy(tx_busy)
);

// File: tb/uart_bc_tx_tb_top.sv
`timescale 1ns/1ps
module uart_bc_tx_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] ph = 3'd0;
   logic       uf_on = 1'b0;
   logic       xfer_tick, tmr_uf;
   logic       cfg_samp_timer = 0, cfg_auto_off = 0, cfg_wait_edge = 0, cfg_invert = 0;
   logic       ten_set = 0, ten_clr = 0, load_valid = 0, col_clr = 0;
   logic [8:0] load_data = '0;
   logic       load_ready, rxd, txd, col_flag, tx_en, tx_busy;
   logic       other_low = 1'b0;
   int         n_chk = 0, n_bad = 0;
   bit         done = 0;

   // row: {data[8:0], invert, samp_timer, auto_off, bad_bit[3:0]} ; bad_bit 15 = none
   localparam logic [15:0] VEC [6] = '{
      {9'h0A5, 1'b0, 1'b0, 1'b0, 4'd15},
      {9'h15A, 1'b1, 1'b0, 1'b0, 4'd15},
      {9'h1FF, 1'b0, 1'b0, 1'b0, 4'd3},
      {9'h1FF, 1'b0, 1'b0, 1'b1, 4'd5},
      {9'h0F0, 1'b1, 1'b1, 1'b1, 4'd6},
      {9'h000, 1'b0, 1'b0, 1'b1, 4'd2}
   };

   always #2 clk = ~clk;
   always_ff @(posedge clk) ph <= ph + 3'd1;
   assign xfer_tick = (ph == 3'd7);
   assign tmr_uf    = uf_on && (ph == 3'd4);
   assign rxd       = ((txd ^ cfg_invert) & ~other_low) ^ cfg_invert;

   uart_bc_tx dut_i (
      .clk(clk), .rst_n(rst_n), .xfer_tick(xfer_tick), .tmr_uf(tmr_uf),
      .cfg_samp_timer(cfg_samp_timer), .cfg_auto_off(cfg_auto_off),
      .cfg_wait_edge(cfg_wait_edge), .cfg_invert(cfg_invert),
      .ten_set(ten_set), .ten_clr(ten_clr), .load_valid(load_valid),
      .load_data(load_data), .load_ready(load_ready), .rxd(rxd), .txd(txd),
      .col_flag(col_flag), .col_clr(col_clr), .tx_en(tx_en), .tx_busy(tx_busy)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_ph(input logic [2:0] p);
      @(negedge clk);
      while (ph != p) @(negedge clk);
   endtask

   function automatic logic ebit(input logic [8:0] d, input int i);
      if (i == 0) return 1'b0;
      if (i >= 10) return 1'b1;
      return d[i-1];
   endfunction

   task automatic cleanup();
      wait_ph(1);
      ten_clr = 1; col_clr = 1;
      @(negedge clk);
      ten_clr = 0; col_clr = 0;
   endtask

   task automatic run_frame(input logic [8:0] d, input logic inv, input logic samp,
                            input logic aoff, input int bad, input logic uf);
      logic col, eb;
      col = (bad <= 10) && ebit(d, bad) && (!samp || uf);
      wait_ph(1);
      cfg_invert = inv; cfg_samp_timer = samp; cfg_auto_off = aoff; uf_on = uf;
      ten_clr = 1; col_clr = 1;
      @(negedge clk);
      ten_clr = 0; col_clr = 0;
      repeat (8) @(negedge clk);
      wait_ph(4);
      load_valid = 1; load_data = d; ten_set = 1;
      @(negedge clk);
      load_valid = 0; ten_set = 0;
      wait_ph(7);
      chk("R3 not started before tick", tx_busy, 0);
      for (int i = 0; i < 11; i++) begin
         wait_ph(0);
         other_low = (i == bad);
         wait_ph(2);
         eb = (col && aoff && i > bad) ? 1'b1 : ebit(d, i);
         if (inv) chk("R5 inverted frame bit", txd, eb ^ inv);
         else     chk("R2 frame bit", txd, eb);
      end
      wait_ph(0);
      other_low = 0;
      wait_ph(2);
      chk("R2 idle after frame", tx_busy, 0);
      if (samp) chk("R7 timer-sampled flag", col_flag, col);
      else      chk("R6 tick-sampled flag", col_flag, col);
      chk("R9 enable after frame", tx_en, !(col && aoff));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog act=timeout exp=finish");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 txd idle", txd, 1);
      chk("R1 tx_en", tx_en, 0);
      chk("R1 col_flag", col_flag, 0);
      chk("R1 load_ready", load_ready, 1);
      chk("R1 tx_busy", tx_busy, 0);

      foreach (VEC[k])
         run_frame(VEC[k][15:7], VEC[k][6], VEC[k][5], VEC[k][4], int'(VEC[k][3:0]), 1'b1);

      // R8: sticky flag and clear
      run_frame(9'h1FF, 0, 0, 0, 3, 1'b1);
      repeat (20) @(negedge clk);
      chk("R8 flag held", col_flag, 1);
      col_clr = 1; @(negedge clk); col_clr = 0;
      chk("R8 flag cleared", col_flag, 0);

      // R7: no timer pulses, mismatch only at ticks
      run_frame(9'h1FF, 0, 1, 1, 4, 1'b0);
      cleanup();

      // R12: idle line, enable on, readback disagrees
      cfg_samp_timer = 0; uf_on = 1;
      ten_set = 1; @(negedge clk); ten_set = 0;
      other_low = 1;
      repeat (24) @(negedge clk);
      chk("R12 no flag while idle", col_flag, 0);
      chk("R12 still idle", tx_busy, 0);
      other_low = 0;
      cleanup();

      // R11 / R10
      cfg_invert = 0; cfg_auto_off = 0; cfg_wait_edge = 0; cfg_samp_timer = 0;
      repeat (8) @(negedge clk);
      load_valid = 1; load_data = 9'h0B3; @(negedge clk); load_valid = 0;
      chk("R11 ready low when pending", load_ready, 0);
      load_valid = 1; load_data = 9'h14C; @(negedge clk); load_valid = 0;
      repeat (16) @(negedge clk);
      chk("R11 no frame while disabled", tx_busy, 0);
      wait_ph(4); ten_set = 1; @(negedge clk); ten_set = 0;
      wait_ph(7);
      for (int i = 0; i < 4; i++) begin
         wait_ph(2);
         chk("R11 first word kept", txd, ebit(9'h0B3, i));
      end
      chk("R11 ready after start", load_ready, 1);
      wait_ph(3); ten_clr = 1; @(negedge clk); ten_clr = 0;
      chk("R10 txd idle after clear", txd, 1);
      chk("R10 busy dropped", tx_busy, 0);
      wait_ph(4);
      load_valid = 1; load_data = 9'h155; ten_set = 1;
      @(negedge clk); load_valid = 0; ten_set = 0;
      wait_ph(7);
      wait_ph(2); chk("R10 restart with start bit", txd, 0);
      wait_ph(2); chk("R10 restart data bit 0", txd, 1);
      cleanup();

      // R4 / R5: edge-triggered start on an inverted line
      cfg_invert = 1; cfg_wait_edge = 1;
      repeat (8) @(negedge clk);
      load_valid = 1; load_data = 9'h0C9; @(negedge clk); load_valid = 0;
      repeat (4) @(negedge clk);
      other_low = 1; repeat (2) @(negedge clk); other_low = 0;
      repeat (16) @(negedge clk);
      chk("R4 edge ignored while disabled", tx_busy, 0);
      chk("R5 inverted idle level", txd, 0);
      ten_set = 1; @(negedge clk); ten_set = 0;
      repeat (24) @(negedge clk);
      chk("R4 ticks do not start frame", tx_busy, 0);
      wait_ph(1);
      other_low = 1; repeat (4) @(negedge clk); other_low = 0;
      wait_ph(6);
      chk("R4 frame started on edge", tx_busy, 1);
      chk("R5 inverted start bit", txd, 1);
      wait_ph(2);
      chk("R4 data bit 0 after edge start", txd, 0);
      cleanup();
      cfg_invert = 0; cfg_wait_edge = 0;
      repeat (8) @(negedge clk);

      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule